// File: doc/BRIEF.md
# Auto-Update Load/Store Address Generator

This block sits in the execute stage of a small pipelined core. It forms the effective memory address for word loads and stores, and the new value of the base register for instructions that step the base by one word. For every accepted instruction it also returns the immediate in the extended 32-bit form that the instruction class needs, so ALU-immediate operations can use the same path.

The issuing logic presents a base register value, a 14-bit immediate field, a 2-bit addressing mode and an instruction class, and raises a valid strobe for one cycle per instruction. One clock later the block presents the address, the updated base, a write-back enable for the base register and the extended immediate, together with an output valid. The block does not access memory and does not arbitrate register-file write ports. It only produces the values and the enable that those stages consume.

Top module: `addr_update_gen`

## Requirements
- R1: After a synchronous reset, `out_valid`, `base_we`, `mem_addr`, `base_new` and `imm_ext` are all zero.
- R2: Each cycle with `in_valid` high produces exactly one result with `out_valid` high in the next cycle. A cycle with `in_valid` low produces `out_valid` low in the next cycle.
- R3: With `op_class` = 1 (logic), `imm_ext` is the immediate zero-extended to 32 bits. With any other class (0 arithmetic, 2 memory, 3 treated as arithmetic), `imm_ext` is the immediate sign-extended from bit 13.
- R4: For a memory instruction (`op_class` = 2) with mode 0, `mem_addr` = base + sign-extended immediate, `base_new` = base, and `base_we` = 0.
- R5: For a memory instruction with mode 1 (post-increment), `mem_addr` = base + sign-extended immediate, `base_new` = base + 4, and `base_we` = 1.
- R6: For a memory instruction with mode 2 (pre-increment), `base_new` = base + 4, `mem_addr` = (base + 4) + sign-extended immediate, and `base_we` = 1.
- R7: For a memory instruction with mode 3 (post-decrement), `mem_addr` = base + sign-extended immediate, `base_new` = base − 4, and `base_we` = 1.
- R8: For classes other than memory, the mode field is ignored. `base_we` = 0, `base_new` = base, and `mem_addr` = base + `imm_ext`, whatever the mode.
- R9: `base_we` is high only in a result cycle of a memory instruction with nonzero mode. While `in_valid` stays low, `mem_addr`, `base_new` and `imm_ext` keep the values of the last result.
- R10: All address and base arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe, one cycle per instruction |
| base_in | input | 32 | Current base register value |
| imm_in | input | 14 | Raw immediate field |
| mode_in | input | 2 | Addressing mode: 0 none, 1 post-inc, 2 pre-inc, 3 post-dec |
| op_class | input | 2 | Instruction class: 0 arithmetic, 1 logic, 2 memory, 3 arithmetic |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| mem_addr | output | 32 | Effective memory address |
| base_new | output | 32 | Base register value to write back |
| base_we | output | 1 | Base register write-back enable |
| imm_ext | output | 32 | Immediate extended for the instruction class |

## Verification
The bench separates pre-increment from post-increment with the same base and immediate. A design that adds the immediate to the old base in mode 2, or to the stepped base in mode 1, gives addresses that differ by 4. It uses a negative immediate and the boundary values 0x1FFF and 0x2000, which a design that always zero-extends or always sign-extends maps to the wrong half of the address space. It sends nonzero modes with the arithmetic and logic classes, where a design that fails to gate the mode would raise `base_we` or change `base_new`. It also steps the base across zero in both directions, which catches a carry or borrow that leaks out or is handled as saturation, and it leaves idle gaps to catch outputs that drift while no instruction is present.

// File: rtl/aug_pkg.sv
package aug_pkg;

  typedef enum logic [1:0] {
    AM_NONE     = 2'd0,
    AM_POST_INC = 2'd1,
    AM_PRE_INC  = 2'd2,
    AM_POST_DEC = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    IC_ARITH = 2'd0,
    IC_LOGIC = 2'd1,
    IC_MEM   = 2'd2,
    IC_RSVD  = 2'd3
  } instr_class_e;

endpackage

// File: rtl/aug_imm_ext.sv
module aug_imm_ext
  import aug_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 14
) (
  input  logic [IMM_W-1:0]  imm,
  input  instr_class_e      cls,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic pad_bit;

  always_comb begin
    pad_bit = (cls == IC_LOGIC) ? 1'b0 : imm[IMM_W-1];
    ext     = {{PAD_W{pad_bit}}, imm};
  end
endmodule

// File: rtl/aug_base_step.sv
module aug_base_step
  import aug_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [DATA_W-1:0] base,
  input  addr_mode_e        mode,
  input  logic              is_mem,
  output logic [DATA_W-1:0] stepped,
  output logic [DATA_W-1:0] addr_base,
  output logic              write_back
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

  addr_mode_e eff_mode;

  always_comb begin
    eff_mode = is_mem ? mode : AM_NONE;
    unique case (eff_mode)
      AM_POST_INC,
      AM_PRE_INC:  stepped = base + STEP;
      AM_POST_DEC: stepped = base - STEP;
      default:     stepped = base;
    endcase
    addr_base  = (eff_mode == AM_PRE_INC) ? stepped : base;
    write_back = (eff_mode != AM_NONE);
  end
endmodule

// File: rtl/aug_out_reg.sv
module aug_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] addr_d,
  input  logic [DATA_W-1:0] base_d,
  input  logic              we_d,
  input  logic [DATA_W-1:0] imm_d,
  output logic              valid_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] base_q,
  output logic              we_q,
  output logic [DATA_W-1:0] imm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
      imm_q   <= '0;
    end else begin
      valid_q <= load;
      we_q    <= load & we_d;
      if (load) begin
        addr_q <= addr_d;
        base_q <= base_d;
        imm_q  <= imm_d;
      end
    end
  end
endmodule

// File: rtl/addr_update_gen.sv
module addr_update_gen
  import aug_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 14,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] base_in,
  input  logic [IMM_W-1:0]  imm_in,
  input  logic [1:0]        mode_in,
  input  logic [1:0]        op_class,
  output logic              out_valid,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] base_new,
  output logic              base_we,
  output logic [DATA_W-1:0] imm_ext
);
  instr_class_e      cls;
  addr_mode_e        mode;
  logic              is_mem;
  logic [DATA_W-1:0] imm_x;
  logic [DATA_W-1:0] stepped;
  logic [DATA_W-1:0] addr_base;
  logic [DATA_W-1:0] addr_d;
  logic              wb;

  always_comb begin
    cls    = instr_class_e'(op_class);
    mode   = addr_mode_e'(mode_in);
    is_mem = (cls == IC_MEM);
    addr_d = addr_base + imm_x;
  end

  aug_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm (imm_in),
    .cls (cls),
    .ext (imm_x)
  );

  aug_base_step #(.DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)) u_step (
    .base       (base_in),
    .mode       (mode),
    .is_mem     (is_mem),
    .stepped    (stepped),
    .addr_base  (addr_base),
    .write_back (wb)
  );

  aug_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .addr_d  (addr_d),
    .base_d  (stepped),
    .we_d    (wb),
    .imm_d   (imm_x),
    .valid_q (out_valid),
    .addr_q  (mem_addr),
    .base_q  (base_new),
    .we_q    (base_we),
    .imm_q   (imm_ext)
  );
endmodule

// File: rtl/aug_chk.sv
module aug_chk #(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 14,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] base_in,
  input logic [IMM_W-1:0]  imm_in,
  input logic [1:0]        mode_in,
  input logic [1:0]        op_class,
  input logic              out_valid,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] base_new,
  input logic              base_we,
  input logic [DATA_W-1:0] imm_ext
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);
  localparam int PAD_W = DATA_W - IMM_W;

  logic mem_in;
  assign mem_in = in_valid && (op_class == 2'd2);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  logic_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class == 2'd1) |=> (imm_ext[DATA_W-1:IMM_W] == '0)
      && (imm_ext[IMM_W-1:0] == $past(imm_in)));

  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class != 2'd1) |=>
      (imm_ext[DATA_W-1:IMM_W] == {PAD_W{imm_ext[IMM_W-1]}}));

  // R4
  mode_none_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_in && mode_in == 2'd0) |=> !base_we && (base_new == $past(base_in))
      && (mem_addr == $past(base_in) + imm_ext));

  // R5
  post_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_in && mode_in == 2'd1) |=> base_we && (base_new == $past(base_in) + STEP)
      && (mem_addr == $past(base_in) + imm_ext));

  // R6
  pre_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_in && mode_in == 2'd2) |=> base_we && (base_new == $past(base_in) + STEP)
      && (mem_addr == base_new + imm_ext));

  // R7
  post_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_in && mode_in == 2'd3) |=> base_we && (base_new == $past(base_in) - STEP)
      && (mem_addr == $past(base_in) + imm_ext));

  // R8
  non_mem_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_class != 2'd2) |=> !base_we && (base_new == $past(base_in)));

  // R9
  we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    base_we |-> out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(mem_addr) && $stable(base_new) && $stable(imm_ext));
endmodule

bind addr_update_gen aug_chk #(
  .DATA_W(DATA_W), .IMM_W(IMM_W), .WORD_BYTES(WORD_BYTES)
) u_aug_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .base_in   (base_in),
  .imm_in    (imm_in),
  .mode_in   (mode_in),
  .op_class  (op_class),
  .out_valid (out_valid),
  .mem_addr  (mem_addr),
  .base_new  (base_new),
  .base_we   (base_we),
  .imm_ext   (imm_ext)
);

// File: tb/addr_update_gen_bench.sv
module addr_update_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] base_in = '0;
  logic [13:0] imm_in = '0;
  logic [1:0]  mode_in = '0;
  logic [1:0]  op_class = '0;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic [31:0] base_new;
  logic        base_we;
  logic [31:0] imm_ext;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;
  logic [31:0] last_addr = '0;

  typedef struct {
    string       tag;
    logic [31:0] addr;
    logic [31:0] bnew;
    logic        we;
    logic [31:0] imm;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  addr_update_gen u_addr_update_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_in(base_in),
    .imm_in(imm_in), .mode_in(mode_in), .op_class(op_class),
    .out_valid(out_valid), .mem_addr(mem_addr), .base_new(base_new),
    .base_we(base_we), .imm_ext(imm_ext)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] cls, logic [1:0] md,
                                 logic [31:0] b, logic [13:0] im, string tag);
    exp_t e;
    e.tag = tag;
    e.imm = (cls == 2'd1) ? {18'h0, im} : {{18{im[13]}}, im};
    if (cls != 2'd2) begin
      e.addr = b + e.imm; e.bnew = b; e.we = 1'b0;
    end else begin
      case (md)
        2'd0: begin e.bnew = b;          e.addr = b + e.imm;      e.we = 1'b0; end
        2'd1: begin e.bnew = b + 32'd4;  e.addr = b + e.imm;      e.we = 1'b1; end
        2'd2: begin e.bnew = b + 32'd4;  e.addr = e.bnew + e.imm; e.we = 1'b1; end
        default: begin e.bnew = b - 32'd4; e.addr = b + e.imm;    e.we = 1'b1; end
      endcase
    end
    return e;
  endfunction

  task automatic drive(logic [1:0] cls, logic [1:0] md, logic [31:0] b,
                       logic [13:0] im, string tag);
    @(negedge clk);
    in_valid = 1'b1; op_class = cls; mode_in = md; base_in = b; imm_in = im;
    sb.push_back(model(cls, md, b, im, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; mode_in = 2'd3; op_class = 2'd2;
      base_in = 32'hDEAD_BEEF; imm_in = 14'h1555;
    end
  endtask

  // monitor: pops expected results as they appear
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R2 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " mem_addr"}, mem_addr, e.addr);
        check({e.tag, " base_new"}, base_new, e.bnew);
        check({e.tag, " base_we"}, {31'b0, base_we}, {31'b0, e.we});
        check({e.tag, " imm_ext"}, imm_ext, e.imm);
        last_addr = e.addr;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 base_we", {31'b0, base_we}, 32'd0);
    check("R1 mem_addr", mem_addr, 32'd0);
    check("R1 base_new", base_new, 32'd0);
    check("R1 imm_ext", imm_ext, 32'd0);

    // R4..R7 memory modes, positive and negative immediates
    drive(2'd2, 2'd0, 32'h0000_1000, 14'h0010, "R4 none");
    drive(2'd2, 2'd1, 32'h0000_1000, 14'h0010, "R5 post-inc");
    drive(2'd2, 2'd2, 32'h0000_1000, 14'h0010, "R6 pre-inc");
    drive(2'd2, 2'd3, 32'h0000_1000, 14'h0010, "R7 post-dec");
    drive(2'd2, 2'd2, 32'h0000_2000, 14'h3FF8, "R6 pre-inc neg imm");
    drive(2'd2, 2'd1, 32'h0000_2000, 14'h3FFC, "R5 post-inc neg imm");
    // R3 boundaries of the immediate
    drive(2'd2, 2'd0, 32'h1000_0000, 14'h1FFF, "R3 mem max pos");
    drive(2'd2, 2'd0, 32'h1000_0000, 14'h2000, "R3 mem min neg");
    drive(2'd1, 2'd0, 32'h0000_0000, 14'h2000, "R3 logic zero-ext");
    drive(2'd0, 2'd0, 32'h0000_0000, 14'h2000, "R3 arith sign-ext");
    drive(2'd3, 2'd0, 32'h0000_0100, 14'h3FFF, "R3 class3 sign-ext");
    // R8 mode ignored outside memory class
    drive(2'd0, 2'd2, 32'h0000_4000, 14'h0004, "R8 arith mode2");
    drive(2'd1, 2'd3, 32'h0000_4000, 14'h3FFF, "R8 logic mode3");
    drive(2'd0, 2'd1, 32'h0000_4000, 14'h0000, "R8 arith mode1");
    // R10 wraparound
    drive(2'd2, 2'd3, 32'h0000_0000, 14'h0000, "R10 dec past zero");
    drive(2'd2, 2'd2, 32'hFFFF_FFFC, 14'h0008, "R10 inc past top");
    drive(2'd2, 2'd1, 32'hFFFF_FFFE, 14'h0003, "R10 post-inc wrap");
    idle(1);
    // R9 hold while idle
    idle(3);
    @(negedge clk);
    check("R9 out_valid idle", {31'b0, out_valid}, 32'd0);
    check("R9 base_we idle", {31'b0, base_we}, 32'd0);
    check("R9 mem_addr hold", mem_addr, last_addr);
    // gap then more traffic
    drive(2'd2, 2'd3, 32'h8000_0000, 14'h0020, "R7 post-dec high");
    idle(1);
    drive(2'd2, 2'd2, 32'h7FFF_FFFC, 14'h0000, "R6 pre-inc sign boundary");
    idle(4);
    check("R2 all results delivered", sb.size(), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule